// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Unit

This block raises the three interrupt causes of a real-time clock and collects them into one status byte with an interrupt request. A periodic cause fires at a rate picked by a 4-bit field. The period is 1,000,000 µs divided by (65536 Hz shifted right by the field). Each timer event reports how many microseconds have passed. That count is added to an accumulator, and when the sum reaches the period, one period is subtracted, so any leftover carries into the next period. An update cause fires on every one-second update. An alarm cause fires on a one-second update when the current hours, minutes and seconds all equal their alarm values.

Each cause has its own enable. A raised flag stays set until the host reads the status byte. The read is signalled by a one-cycle pulse, and it clears all flags and drops the request. Calendar counting sits outside this block. The current time and the alarm time arrive on input ports.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, `stat_c` is 8'h00 and `irq` is 0.
- R2: The periodic period for rate values 1 to 15 is 1000000 / (65536 >> rate) µs, using integer division (rate 1 = 30 µs, rate 6 = 976 µs, rate 15 = 500000 µs). With `per_en` high, the periodic flag (`stat_c` bit 6) sets in the cycle after the `tick_vld` pulse that brings the accumulated `tick_us` total to the period or beyond.
- R3: On a periodic hit, one period is subtracted from the accumulator rather than clearing it. For example, with rate 1 and steps of 7 µs from zero, the hits come on the 5th and 9th ticks.
- R4: While `per_en` is low or `rate` is 0, no periodic flag is raised and the accumulator is held at zero, so re-enabling starts a fresh period.
- R5: A `sec_tick` pulse with `upd_en` high sets the update flag (`stat_c` bit 4). With `upd_en` low it leaves `stat_c` unchanged.
- R6: A `sec_tick` pulse with `alm_en` high sets the alarm flag (`stat_c` bit 5) only when all three pairs match: `cur_sec` with `alm_sec`, `cur_min` with `alm_min`, and `cur_hour` with `alm_hour`. A mismatch, or `alm_en` low, leaves the alarm flag clear.
- R7: `stat_c` bit 7 is the OR of bits 6, 5 and 4. Bits 3:0 always read 0.
- R8: `irq` is high exactly when `stat_c` bit 7 is high.
- R9: Flags stay set until a `stat_rd` pulse. One cycle after that pulse, all flags and `irq` are 0.
- R10: An event arriving in the same cycle as `stat_rd` is not lost: its flag is set after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_vld | input | 1 | Timer event pulse |
| tick_us | input | STEP_W | Microseconds elapsed since the previous timer event |
| sec_tick | input | 1 | One-second update pulse |
| rate | input | 4 | Periodic rate select; 0 turns the periodic cause off |
| per_en | input | 1 | Periodic cause enable |
| alm_en | input | 1 | Alarm cause enable |
| upd_en | input | 1 | Update cause enable |
| cur_sec | input | TIME_W | Current seconds |
| cur_min | input | TIME_W | Current minutes |
| cur_hour | input | TIME_W | Current hours |
| alm_sec | input | TIME_W | Alarm seconds |
| alm_min | input | TIME_W | Alarm minutes |
| alm_hour | input | TIME_W | Alarm hours |
| stat_rd | input | 1 | Status read pulse; clears all flags |
| stat_c | output | 8 | Status byte: bit 7 any, 6 periodic, 5 alarm, 4 update |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- read-to-clear when no event coincides with the read;
- flag stickiness;
- the update flag following an enabled one-second pulse;
- the alarm flag appearing only after an enabled one-second pulse;
- the request tracking the summary bit;
- the accumulator resting at zero while the periodic cause is off.

Only the bench's scenarios can show two things. The first is the count and exact tick position of periodic hits for a given rate and step, which proves the remainder is carried rather than dropped. The second is full three-field matching for the alarm, including near-miss times.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int RATE_W    = 4;
    localparam int RATE_N    = 1 << RATE_W;
    localparam int N_FIELDS  = 3;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } irq_flags_t;
endpackage

// File: rtl/rtc_period_gen.sv
module rtc_period_gen
    import rtc_irq_pkg::*;
#(
    parameter int BASE_HZ    = 65536,
    parameter int US_PER_SEC = 1000000,
    parameter int STEP_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] rate,
    input  logic              tick_vld,
    input  logic [STEP_W-1:0] tick_us,
    output logic              hit
);
    localparam int PER_W = $clog2(US_PER_SEC + 1);
    localparam int ACC_W = PER_W + 1;
    localparam int SUM_W = ((ACC_W > STEP_W) ? ACC_W : STEP_W) + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } pg_state_t;

    pg_state_t st_d, st_q;

    logic [PER_W-1:0] per_tab [RATE_N];
    for (genvar g = 0; g < RATE_N; g++) begin : g_tab
        assign per_tab[g] = PER_W'(US_PER_SEC / (BASE_HZ >> g));
    end

    logic             active;
    logic [PER_W-1:0] period;
    logic [SUM_W-1:0] sum;

    always_comb begin
        st_d   = st_q;
        hit    = 1'b0;
        active = en && (rate != '0);
        period = per_tab[rate];
        sum    = SUM_W'(st_q.acc) + SUM_W'(tick_us);
        if (!active) begin
            st_d.acc = '0;
        end else if (tick_vld) begin
            if (sum >= SUM_W'(period)) begin
                st_d.acc = ACC_W'(sum - SUM_W'(period));
                hit      = 1'b1;
            end else begin
                st_d.acc = ACC_W'(sum);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: accumulator rests at zero after an inactive cycle
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.acc == '0));
    // R4: no periodic hit with rate zero
    p_hit_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (rate != '0) && en);
    // R2: hits only on a timer event
    p_hit_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> tick_vld);
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_irq_pkg::*;
#(
    parameter int TIME_W = 8
) (
    input  logic [N_FIELDS-1:0][TIME_W-1:0] now_t,
    input  logic [N_FIELDS-1:0][TIME_W-1:0] alm_t,
    output logic                            match
);
    logic [N_FIELDS-1:0] eq;
    for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
        assign eq[g] = (now_t[g] == alm_t[g]);
    end
    assign match = &eq;
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_irq_pkg::*;
#(
    parameter int BASE_HZ    = 65536,
    parameter int US_PER_SEC = 1000000,
    parameter int STEP_W     = 16,
    parameter int TIME_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_vld,
    input  logic [STEP_W-1:0] tick_us,
    input  logic              sec_tick,
    input  logic [RATE_W-1:0] rate,
    input  logic              per_en,
    input  logic              alm_en,
    input  logic              upd_en,
    input  logic [TIME_W-1:0] cur_sec,
    input  logic [TIME_W-1:0] cur_min,
    input  logic [TIME_W-1:0] cur_hour,
    input  logic [TIME_W-1:0] alm_sec,
    input  logic [TIME_W-1:0] alm_min,
    input  logic [TIME_W-1:0] alm_hour,
    input  logic              stat_rd,
    output logic [7:0]        stat_c,
    output logic              irq
);
    typedef struct packed {
        irq_flags_t flags;
        logic       req;
    } unit_state_t;

    unit_state_t st_d, st_q;
    logic        per_hit;
    logic        alm_match;

    rtc_period_gen #(
        .BASE_HZ    (BASE_HZ),
        .US_PER_SEC (US_PER_SEC),
        .STEP_W     (STEP_W)
    ) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (per_en),
        .rate     (rate),
        .tick_vld (tick_vld),
        .tick_us  (tick_us),
        .hit      (per_hit)
    );

    rtc_alarm_cmp #(
        .TIME_W (TIME_W)
    ) u_alarm (
        .now_t (  {cur_hour, cur_min, cur_sec}),
        .alm_t (  {alm_hour, alm_min, alm_sec}),
        .match (alm_match)
    );

    always_comb begin
        st_d = st_q;
        if (stat_rd) st_d.flags = '0;
        if (per_hit)                        st_d.flags.per = 1'b1;
        if (sec_tick && alm_en && alm_match) st_d.flags.alm = 1'b1;
        if (sec_tick && upd_en)             st_d.flags.upd = 1'b1;
        st_d.req = st_d.flags.per | st_d.flags.alm | st_d.flags.upd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat_c    = '0;
        stat_c[7] = st_q.flags.per | st_q.flags.alm | st_q.flags.upd;
        stat_c[6] = st_q.flags.per;
        stat_c[5] = st_q.flags.alm;
        stat_c[4] = st_q.flags.upd;
    end
    assign irq = st_q.req;

    // R9: a read with no coinciding event empties the byte
    p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !sec_tick && !per_hit |=> (stat_c == 8'h00) && !irq);
    // R9: update flag holds until read
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_c[4] && !stat_rd |=> stat_c[4]);
    // R5, R10: enabled second pulse sets the update flag even during a read
    p_upd_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick && upd_en |=> stat_c[4]);
    // R6: alarm flag only after an enabled second pulse
    p_alm_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_c[5]) |-> $past(sec_tick && alm_en));
    // R8: request tracks the summary bit
    p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == stat_c[7]);
endmodule

// File: tb/rtc_irq_unit_tb.sv
module rtc_irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_vld = 1'b0;
    logic [15:0] tick_us = '0;
    logic        sec_tick = 1'b0;
    logic [3:0]  rate = 4'd0;
    logic        per_en = 1'b0, alm_en = 1'b0, upd_en = 1'b0;
    logic [7:0]  cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic [7:0]  alm_sec = '0, alm_min = '0, alm_hour = '0;
    logic        stat_rd = 1'b0;
    logic [7:0]  stat_c;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tick_vld(tick_vld), .tick_us(tick_us),
        .sec_tick(sec_tick), .rate(rate), .per_en(per_en), .alm_en(alm_en),
        .upd_en(upd_en), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .stat_rd(stat_rd), .stat_c(stat_c), .irq(irq)
    );

    typedef struct packed {
        logic [3:0]  rt;
        logic [15:0] step;
        logic [7:0]  n;
        logic [7:0]  hits;
    } vec_t;

    // R2: hits = floor(n*step / period)
    localparam vec_t VECS [8] = '{
        '{4'd1,  16'd7,     8'd20, 8'd4},
        '{4'd6,  16'd100,   8'd30, 8'd3},
        '{4'd3,  16'd61,    8'd10, 8'd5},
        '{4'd15, 16'd50000, 8'd12, 8'd1},
        '{4'd10, 16'd15625, 8'd4,  8'd4},
        '{4'd0,  16'd30,    8'd10, 8'd0},
        '{4'd2,  16'd60,    8'd5,  8'd4},
        '{4'd9,  16'd1000,  8'd16, 8'd2}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic [15:0] us);
        @(negedge clk); tick_vld = 1'b1; tick_us = us;
        @(negedge clk); tick_vld = 1'b0;
    endtask

    task automatic sec_pulse();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic restart_per(input logic [3:0] r);
        @(negedge clk); per_en = 1'b0; rate = r;
        @(negedge clk); per_en = 1'b1;
    endtask

    initial begin
        int hits;
        int last;
        repeat (3) @(negedge clk);
        check("R1 reset stat_c", 32'(stat_c), 32'h00);
        check("R1 reset irq", 32'(irq), 32'h0);
        rst_n = 1'b1;

        // table walk
        for (int v = 0; v < 8; v++) begin
            restart_per(VECS[v].rt);
            rd();
            hits = 0;
            for (int t = 0; t < int'(VECS[v].n); t++) begin
                tick(VECS[v].step);
                if (stat_c[6]) begin
                    hits++;
                    check("R7 byte on periodic", 32'(stat_c), 32'hC0);
                    check("R8 irq on periodic", 32'(irq), 32'h1);
                    rd();
                end
            end
            check((VECS[v].rt == 4'd0) ? "R4 rate zero hits" : "R2 periodic hits",
                  32'(hits), 32'(VECS[v].hits));
        end

        // R3: remainder carried, second hit on tick 9
        restart_per(4'd1);
        rd();
        hits = 0; last = 0;
        for (int t = 1; t <= 9; t++) begin
            tick(16'd7);
            if (stat_c[6]) begin hits++; last = t; rd(); end
        end
        check("R3 hit count", 32'(hits), 32'd2);
        check("R3 second hit tick", 32'(last), 32'd9);

        // R4: disabled enable blocks hits
        @(negedge clk); per_en = 1'b0; rate = 4'd1;
        for (int t = 0; t < 4; t++) tick(16'd30);
        check("R4 per_en low", 32'(stat_c), 32'h00);

        // R4: re-enable starts a fresh period
        restart_per(4'd1);
        tick(16'd20);
        @(negedge clk); per_en = 1'b0;
        @(negedge clk); per_en = 1'b1;
        tick(16'd20);
        check("R4 fresh period", 32'(stat_c[6]), 32'h0);
        tick(16'd20);
        check("R4 period after restart", 32'(stat_c[6]), 32'h1);
        @(negedge clk); per_en = 1'b0;
        rd();

        // R5: update flag
        upd_en = 1'b1;
        sec_pulse();
        check("R5 update byte", 32'(stat_c), 32'h90);
        check("R8 irq on update", 32'(irq), 32'h1);
        rd();
        check("R9 clear after read", 32'(stat_c), 32'h00);
        check("R9 irq low after read", 32'(irq), 32'h0);
        upd_en = 1'b0;
        sec_pulse();
        check("R5 update disabled", 32'(stat_c), 32'h00);

        // R6: alarm
        cur_sec = 8'h45; cur_min = 8'h12; cur_hour = 8'h07;
        alm_sec = 8'h45; alm_min = 8'h12; alm_hour = 8'h07;
        alm_en = 1'b1;
        sec_pulse();
        check("R6 alarm match", 32'(stat_c), 32'hA0);
        // R9: flag held while no read
        repeat (3) @(negedge clk);
        check("R9 alarm sticky", 32'(stat_c), 32'hA0);
        rd();
        alm_min = 8'h13;
        sec_pulse();
        check("R6 minute mismatch", 32'(stat_c), 32'h00);
        alm_min = 8'h12; alm_hour = 8'h08;
        sec_pulse();
        check("R6 hour mismatch", 32'(stat_c), 32'h00);
        alm_hour = 8'h07; alm_en = 1'b0;
        sec_pulse();
        check("R6 alarm disabled", 32'(stat_c), 32'h00);

        // R10: event coinciding with read survives
        alm_en = 1'b1;
        sec_pulse();
        check("R6 alarm again", 32'(stat_c), 32'hA0);
        alm_en = 1'b0; upd_en = 1'b1;
        @(negedge clk); stat_rd = 1'b1; sec_tick = 1'b1;
        @(negedge clk); stat_rd = 1'b0; sec_tick = 1'b0;
        check("R10 event during read", 32'(stat_c), 32'h90);
        check("R7 low nibble zero", 32'(stat_c[3:0]), 32'h0);
        upd_en = 1'b0;
        rd();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule